// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Unit

This block collects interrupt requests from a row of source cells and settles which one the processor serves. All cells feed one shared request line. When the processor answers with an acknowledge, that acknowledge enters cell 0 and moves along the row one cell at a time. A cell with nothing pending passes it on. The first cell holding a request keeps it, blocks every cell further down, and drives its own programmed vector onto the vector bus. Priority therefore follows only from a cell's place in the row. No central encoder is involved.

Each cell stores a vector that is loaded through a configuration write port. A granted cell drops its pending request at the clock edge that ends the acknowledge cycle. The shared line then stays high only while other cells still hold requests. When an acknowledge finds no requester, the bus reads zero and an empty flag is raised. The acknowledge that leaves the last cell is brought out, so further rows can be attached below this one.

Top module: `irq_chain_top`

## Requirements
- R1: After reset no cell is pending, `irq_o` is 0 and every cell's vector is 0. `irq_o` is 1 exactly when at least one cell is pending.
- R2: A 1 on `req_i[i]` at a rising clock edge makes cell i pending from the following cycle. The cell then stays pending until it is granted.
- R3: While `ack_i` is 1, the pending cell with the lowest index wins in the same cycle. `grant_o` is one-hot at that index, and `vec_bus_o` carries that cell's vector.
- R4: Cells below the winner see no acknowledge and are not granted. `chain_out_o` is 1 only when `ack_i` is 1 and no cell is pending.
- R5: A granted cell is no longer pending after the edge that ends the acknowledge cycle. If its own `req_i` bit is 1 at that same edge, the new request wins and the cell stays pending.
- R6: If `ack_i` is 1 and no cell is pending, `vec_bus_o` is 0 and `no_vec_o` is 1. If any cell wins, `no_vec_o` is 0.
- R7: `cfg_we_i` = 1 at an edge loads `cfg_vec_i` into the vector of cell `cfg_sel_i`. The vectors of all other cells stay unchanged.
- R8: While `ack_i` is 0, no cell is granted, `vec_bus_o` and `no_vec_o` are 0, and pending requests are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_SRC | Per-cell request; a 1 at an edge sets that cell pending |
| ack_i | input | 1 | Processor acknowledge entering cell 0 |
| cfg_we_i | input | 1 | Vector write enable |
| cfg_sel_i | input | IDX_W | Index of the cell whose vector is written |
| cfg_vec_i | input | VEC_W | Vector value to store |
| irq_o | output | 1 | Shared request line, OR of all pending cells |
| vec_bus_o | output | VEC_W | Vector of the winning cell, zero when none wins |
| no_vec_o | output | 1 | Acknowledge present with no winner |
| grant_o | output | NUM_SRC | One-hot flag of the winning cell |
| chain_out_o | output | 1 | Acknowledge passed out of the last cell |

## Verification
A cell's grant and a fresh request from that same cell can land on one clock edge. The grant tries to clear the pending bit while the request tries to set it. The bench provokes this by holding `req_i[0]` high during the acknowledge cycle in which cell 0 wins. It then judges the result at the ports: `irq_o` must stay high, and the next acknowledge must grant cell 0 again with its vector. A second overlap sets a new request in a lower cell while a higher cell is being drained. The drain order must still follow the index order.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  parameter int unsigned DEF_SRC   = 4;
  parameter int unsigned DEF_VEC_W = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/irq_cell.sv
module irq_cell #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned MY_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             pi_i,
  output logic             po_o,
  output logic             win_o,
  output logic             pend_o,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_sel_i,
  input  logic [VEC_W-1:0] cfg_vec_i,
  output logic [VEC_W-1:0] vec_o
);
  logic             pend_q, pend_d, pend_en;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;
  logic             win;

  // acknowledge pass-through and capture
  always_comb begin
    win  = pi_i & pend_q;
    po_o = pi_i & ~pend_q;
  end

  // pending next state: a new request wins over a grant
  always_comb begin
    pend_en = req_i | win;
    pend_d  = req_i;
  end

  // vector load next state
  always_comb begin
    vec_en = cfg_we_i && (cfg_sel_i == IDX_W'(MY_IDX));
    vec_d  = cfg_vec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  assign win_o  = win;
  assign pend_o = pend_q;
  assign vec_o  = win ? vec_q : '0;
endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [NUM_SRC*VEC_W-1:0] vec_flat_i,
  output logic [VEC_W-1:0]         bus_o
);
  logic [VEC_W-1:0] acc [NUM_SRC+1];

  assign acc[0] = '0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
    assign acc[g+1] = acc[g] | vec_flat_i[g*VEC_W +: VEC_W];
  end

  assign bus_o = acc[NUM_SRC];
endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top #(
  parameter int unsigned NUM_SRC = irq_chain_pkg::DEF_SRC,
  parameter int unsigned VEC_W   = irq_chain_pkg::DEF_VEC_W,
  parameter int unsigned IDX_W   = irq_chain_pkg::idx_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ack_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_sel_i,
  input  logic [VEC_W-1:0]   cfg_vec_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_bus_o,
  output logic               no_vec_o,
  output logic [NUM_SRC-1:0] grant_o,
  output logic               chain_out_o
);
  localparam int unsigned FLAT_W = NUM_SRC * VEC_W;

  logic               rst_sync_n;
  logic [NUM_SRC:0]   chain;
  logic [NUM_SRC-1:0] win_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic [FLAT_W-1:0]  vec_flat;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign chain[0] = ack_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    irq_cell #(
      .VEC_W  (VEC_W),
      .IDX_W  (IDX_W),
      .MY_IDX (g)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .req_i     (req_i[g]),
      .pi_i      (chain[g]),
      .po_o      (chain[g+1]),
      .win_o     (win_vec[g]),
      .pend_o    (pend_vec[g]),
      .cfg_we_i  (cfg_we_i),
      .cfg_sel_i (cfg_sel_i),
      .cfg_vec_i (cfg_vec_i),
      .vec_o     (vec_flat[g*VEC_W +: VEC_W])
    );
  end

  irq_vec_merge #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
  ) u_merge (
    .vec_flat_i (vec_flat),
    .bus_o      (vec_bus_o)
  );

  assign irq_o       = |pend_vec;
  assign grant_o     = win_vec;
  assign no_vec_o    = ack_i & ~(|win_vec);
  assign chain_out_o = chain[NUM_SRC];
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_bus_o,
  input logic               no_vec_o,
  input logic [NUM_SRC-1:0] grant_o,
  input logic               chain_out_o,
  input logic [NUM_SRC-1:0] pend_vec
);
  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(grant_o));

  a_r3_winner_exists: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ack_i && irq_o) |-> ($countones(grant_o) == 1 && !no_vec_o));

  a_r2_req_raises_line: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|req_i) |=> irq_o);

  a_r4_chain_out_empty: assert property (@(posedge clk) disable iff (!rst_q_n)
    chain_out_o |-> (ack_i && !irq_o));

  a_r5_last_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ack_i && irq_o && pend_vec == grant_o && req_i == '0) |=> !irq_o);

  a_r6_empty_ack: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ack_i && !irq_o) |-> (no_vec_o && vec_bus_o == '0));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ack_i |-> (grant_o == '0 && vec_bus_o == '0 && !no_vec_o));

  a_r8_pending_kept: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ack_i && irq_o) |=> irq_o);
endmodule

bind irq_chain_top irq_chain_chk #(
  .NUM_SRC (NUM_SRC),
  .VEC_W   (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_sync_n),
  .req_i       (req_i),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .vec_bus_o   (vec_bus_o),
  .no_vec_o    (no_vec_o),
  .grant_o     (grant_o),
  .chain_out_o (chain_out_o),
  .pend_vec    (pend_vec)
);

// File: tb/irq_chain_top_bench.sv
module irq_chain_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int VW = 8;
  localparam int IW = 2;
  localparam int NUM_ROWS = 7;

  // {pattern, first grant, first vector, no-vector flag}
  localparam logic [16:0] TBL [NUM_ROWS] = '{
    {4'b0001, 4'b0001, 8'h11, 1'b0},
    {4'b0110, 4'b0010, 8'h22, 1'b0},
    {4'b1000, 4'b1000, 8'h44, 1'b0},
    {4'b1111, 4'b0001, 8'h11, 1'b0},
    {4'b1100, 4'b0100, 8'h33, 1'b0},
    {4'b0000, 4'b0000, 8'h00, 1'b1},
    {4'b1010, 4'b0010, 8'h22, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_i;
  logic          ack_i;
  logic          cfg_we_i;
  logic [IW-1:0] cfg_sel_i;
  logic [VW-1:0] cfg_vec_i;
  logic          irq_o;
  logic [VW-1:0] vec_bus_o;
  logic          no_vec_o;
  logic [N-1:0]  grant_o;
  logic          chain_out_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [VW-1:0] exp_vec [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_chain_top #(.NUM_SRC(N), .VEC_W(VW)) u_irq_chain_top (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_vec_i(cfg_vec_i),
    .irq_o(irq_o), .vec_bus_o(vec_bus_o), .no_vec_o(no_vec_o),
    .grant_o(grant_o), .chain_out_o(chain_out_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [N-1:0] lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [VW-1:0] vec_of(input logic [N-1:0] g);
    for (int i = 0; i < N; i++) if (g[i]) return exp_vec[i];
    return '0;
  endfunction

  // acknowledge until the model mask is empty, checking each winner
  task automatic drain(input logic [N-1:0] mask_in);
    logic [N-1:0] mask = mask_in;
    logic [N-1:0] g;
    while (mask != '0) begin
      ack_i = 1'b1;
      #1;
      g = lowest(mask);
      chk(grant_o == g, "R3", "drain grant", grant_o, g);
      chk(vec_bus_o == vec_of(g), "R3", "drain vector", vec_bus_o, vec_of(g));
      chk(chain_out_o == 1'b0, "R4", "chain blocked", chain_out_o, 0);
      tick();
      mask = mask & ~g;
      ack_i = 1'b0;
      #1;
      chk(irq_o == (mask != '0), "R5", "line after grant", irq_o, mask != '0);
    end
    ack_i = 1'b0;
  endtask

  task automatic set_req(input logic [N-1:0] p);
    req_i = p;
    tick();
    req_i = '0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = '0; ack_i = 1'b0;
    cfg_we_i = 1'b0; cfg_sel_i = '0; cfg_vec_i = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    chk(irq_o == 1'b0, "R1", "irq after reset", irq_o, 0);
    chk(vec_bus_o == '0 && no_vec_o == 1'b0, "R1", "bus after reset", vec_bus_o, 0);
    for (int i = 0; i < N; i++) exp_vec[i] = '0;
    set_req(4'b0100);
    drain(4'b0100);   // vector of cell 2 still zero (R1)

    // R7: load vectors
    for (int i = 0; i < N; i++) begin
      cfg_we_i = 1'b1; cfg_sel_i = IW'(i); cfg_vec_i = VW'((i + 1) * 17);
      exp_vec[i] = VW'((i + 1) * 17);
      tick();
    end
    cfg_we_i = 1'b0;

    // table walk: R2, R3, R6
    for (int r = 0; r < NUM_ROWS; r++) begin
      logic [N-1:0]  pat = TBL[r][16:13];
      logic [N-1:0]  g0  = TBL[r][12:9];
      logic [VW-1:0] v0  = TBL[r][8:1];
      logic          nv  = TBL[r][0];
      set_req(pat);
      chk(irq_o == (pat != '0), "R2", "line after request", irq_o, pat != '0);
      ack_i = 1'b1;
      #1;
      chk(grant_o == g0, "R3", "first grant", grant_o, g0);
      chk(vec_bus_o == v0, "R6", "first vector", vec_bus_o, v0);
      chk(no_vec_o == nv, "R6", "no-vector flag", no_vec_o, nv);
      chk(chain_out_o == (pat == '0), "R4", "chain out", chain_out_o, pat == '0);
      ack_i = 1'b0;
      #1;
      drain(pat);
    end

    // R8: without acknowledge nothing is granted and pending is kept
    set_req(4'b0011);
    repeat (3) tick();
    chk(grant_o == '0 && vec_bus_o == '0, "R8", "no ack no grant", grant_o, 0);
    chk(irq_o == 1'b1, "R8", "pending kept", irq_o, 1);
    drain(4'b0011);

    // R5: request and grant of cell 0 on one edge, set wins
    set_req(4'b0001);
    ack_i = 1'b1; req_i = 4'b0001;
    tick();
    ack_i = 1'b0; req_i = '0;
    #1;
    chk(irq_o == 1'b1, "R5", "set wins over clear", irq_o, 1);
    drain(4'b0001);

    // R5/R3: new lower-priority request during a drain
    set_req(4'b0010);
    ack_i = 1'b1; req_i = 4'b1000;
    #1;
    chk(grant_o == 4'b0010, "R3", "grant with new request", grant_o, 4'b0010);
    tick();
    ack_i = 1'b0; req_i = '0;
    #1;
    drain(4'b1000);

    // R7: rewrite one vector, others unchanged
    cfg_we_i = 1'b1; cfg_sel_i = 2'd2; cfg_vec_i = 8'h5A;
    exp_vec[2] = 8'h5A;
    tick();
    cfg_we_i = 1'b0;
    set_req(4'b1111);
    drain(4'b1111);

    // R4/R6: empty acknowledge
    ack_i = 1'b1;
    #1;
    chk(chain_out_o == 1'b1 && no_vec_o == 1'b1, "R4", "empty pass", chain_out_o, 1);
    ack_i = 1'b0;
    tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule